// File: doc/BRIEF.md
# Three-Channel Square-Wave Sound Generator

This block generates three square-wave tones and a shared pseudo-random noise stream. It gates them per channel through a mixer and produces one 4-bit amplitude for each channel. Software reaches sixteen 8-bit registers indirectly. A write to the select port latches a register index. Data-port writes then land in that register, and the select port reads back its contents. The index stays in effect until it is rewritten.

All timing derives from a sound-clock enable. Every sixteenth enabled cycle is a divided tick. The tone and noise counters advance on these ticks. A channel's level comes either from a fixed 4-bit field or from an external envelope level input, and the channel's mixed output gates that level. A direction bit for an external I/O port is also brought out.

Top module: `psg_core`

## Requirements
- R1: A write on the select port stores bits 3:0 of the write data as the current register index, and upper bits are ignored. `rdata_o` always shows the full 8-bit contents of the selected register.
- R2: The index holds across any number of data-port writes. Each data write replaces only the selected register.
- R3: Registers 0/1, 2/3 and 4/5 are the low/high period bytes of channels A, B and C. The 12-bit period is {high[3:0], low[7:0]}. High bits 7:4 are ignored, and a period of 0 acts as 1.
- R4: A divided tick occurs on every 16th cycle with `snd_en_i` high. Each tone output starts low after reset and inverts every P ticks, where P is the period in effect.
- R5: The noise period is bits 4:0 of register 6, with 0 acting as 1. The noise shift register advances once every noise-period ticks.
- R6: The noise shift register is 17 bits wide and resets to 1. On each advance it shifts right and loads bit 0 XOR bit 3 into bit 16. The noise output is bit 0.
- R7: In register 7, bits 0..2 disable tone and bits 3..5 disable noise for channels A..C, where 0 means enabled. A channel is high when (tone OR tone-disabled) AND (noise OR noise-disabled).
- R8: `io_in_o` equals bit 6 of register 7.
- R9: Registers 8, 9 and 10 set the levels of channels A, B and C. When the channel is high, its amplitude is `env_lvl_i` if bit 4 is 1, and bits 3:0 otherwise. A low channel gives amplitude 0.
- R10: After reset, all registers and the index are 0, all tones are low, and every amplitude is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_we_i | input | 1 | Write strobe of the select port |
| data_we_i | input | 1 | Write strobe of the data port |
| wdata_i | input | 8 | Write data for both ports |
| rdata_o | output | 8 | Contents of the selected register |
| snd_en_i | input | 1 | Sound clock enable |
| env_lvl_i | input | 4 | Level from the envelope block |
| chan_o | output | 3 | Mixed output of channels A..C |
| amp_o | output | 12 | Amplitudes, channel i at bits 4i+3:4i |
| io_in_o | output | 1 | I/O port direction, 1 = input |

## Verification
The register interface is exercised in three ways:
- A full write-then-read sweep over all sixteen indices.
- Repeated data writes under one held index.
- An index written with high bits set.

Tone timing runs from reset with three different periods at once. The bench enables one tick at a time and compares every tick against (k / P) mod 2. The periods include a zero period and one that relies on the ignored high nibble, which separates the three channels and exposes off-by-one counting. The noise stream is compared tick by tick against an arithmetic LFSR model under a mixer setting that ANDs tone with noise on one channel and forces another channel high. Level sweeps over all 16 fixed and all 16 envelope values separate the two amplitude sources.

// File: rtl/psg_pkg.sv
package psg_pkg;
  parameter int unsigned DATA_W   = 8;
  parameter int unsigned NUM_REGS = 16;
  parameter int unsigned NUM_CH   = 3;
  parameter int unsigned LVL_W    = 4;
  parameter int unsigned TONE_W   = 12;
  parameter int unsigned NOISE_W  = 5;
  parameter int unsigned LFSR_W   = 17;
  parameter int unsigned PRESCALE = 16;
  localparam int unsigned IDX_W   = $clog2(NUM_REGS);

  localparam int unsigned REG_NOISE = 6;
  localparam int unsigned REG_MIX   = 7;
  localparam int unsigned REG_LVL0  = 8;
  localparam int unsigned MIX_DIR   = 6;
  localparam int unsigned LVL_ENV   = 4;

  typedef logic [NUM_REGS-1:0][DATA_W-1:0] reg_bank_t;
endpackage

// File: rtl/psg_regfile.sv
module psg_regfile
  import psg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_we_i,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output reg_bank_t         regs_o
);
  logic [IDX_W-1:0] sel_q;
  reg_bank_t        regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else if (addr_we_i) sel_q <= wdata_i[IDX_W-1:0];
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[r] <= '0;
      else if (data_we_i && sel_q == IDX_W'(r)) regs_q[r] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[sel_q];
  assign regs_o  = regs_q;

  p_sel_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_we_i |=> $stable(sel_q));
  p_data_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && !addr_we_i) |=> rdata_o == $past(wdata_i));
endmodule

// File: rtl/psg_tone.sv
module psg_tone
  import psg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [TONE_W-1:0] period_i,
  output logic              tone_o
);
  logic [TONE_W-1:0] cnt_q, eff;
  logic              wrap;

  assign eff  = (period_i == '0) ? TONE_W'(1) : period_i;
  assign wrap = ({1'b0, cnt_q} + 1'b1) >= {1'b0, eff};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tone_o <= 1'b0;
    end else if (tick_i) begin
      if (wrap) begin
        cnt_q  <= '0;
        tone_o <= ~tone_o;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_tone_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(tone_o));
endmodule

// File: rtl/psg_noise.sv
module psg_noise
  import psg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [NOISE_W-1:0] period_i,
  output logic               noise_o
);
  logic [NOISE_W-1:0] cnt_q, eff;
  logic [LFSR_W-1:0]  lfsr_q;
  logic               wrap;

  assign eff  = (period_i == '0) ? NOISE_W'(1) : period_i;
  assign wrap = ({1'b0, cnt_q} + 1'b1) >= {1'b0, eff};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lfsr_q <= LFSR_W'(1);
    end else if (tick_i) begin
      if (wrap) begin
        cnt_q  <= '0;
        lfsr_q <= {lfsr_q[0] ^ lfsr_q[3], lfsr_q[LFSR_W-1:1]};
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign noise_o = lfsr_q[0];

  p_lfsr_live_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);
  p_lfsr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(lfsr_q));
endmodule

// File: rtl/psg_core.sv
module psg_core
  import psg_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    addr_we_i,
  input  logic                    data_we_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [DATA_W-1:0]       rdata_o,
  input  logic                    snd_en_i,
  input  logic [LVL_W-1:0]        env_lvl_i,
  output logic [NUM_CH-1:0]       chan_o,
  output logic [NUM_CH*LVL_W-1:0] amp_o,
  output logic                    io_in_o
);
  localparam int unsigned PS_W = $clog2(PRESCALE);

  reg_bank_t         regs;
  logic [PS_W-1:0]   ps_q;
  logic              tick;
  logic [NUM_CH-1:0] tone;
  logic              noise;

  psg_regfile i_regfile (
    .clk_i, .rst_ni, .addr_we_i, .data_we_i, .wdata_i,
    .rdata_o, .regs_o(regs)
  );

  // divided tick on the last enabled cycle of each prescale window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ps_q <= '0;
    else if (snd_en_i) ps_q <= ps_q + 1'b1;
  end
  assign tick = snd_en_i && (ps_q == PS_W'(PRESCALE - 1));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [TONE_W-1:0] per;
    logic [DATA_W-1:0] lvl_reg;
    logic              on;

    assign per = {regs[2*c+1][TONE_W-DATA_W-1:0], regs[2*c]};

    psg_tone i_tone (
      .clk_i, .rst_ni, .tick_i(tick), .period_i(per), .tone_o(tone[c])
    );

    assign on = (tone[c] | regs[REG_MIX][c]) & (noise | regs[REG_MIX][NUM_CH + c]);
    assign chan_o[c] = on;
    assign lvl_reg = regs[REG_LVL0 + c];
    assign amp_o[c*LVL_W +: LVL_W] = !on ? '0 :
                                     lvl_reg[LVL_ENV] ? env_lvl_i : lvl_reg[LVL_W-1:0];

    p_mute_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !chan_o[c] |-> amp_o[c*LVL_W +: LVL_W] == '0);
  end

  psg_noise i_noise (
    .clk_i, .rst_ni, .tick_i(tick),
    .period_i(regs[REG_NOISE][NOISE_W-1:0]), .noise_o(noise)
  );

  assign io_in_o = regs[REG_MIX][MIX_DIR];

  p_tick_spacing_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> !tick);
endmodule

// File: tb/test_psg_core.sv
module test_psg_core;
  logic clk = 0, rst_n = 0;
  logic addr_we = 0, data_we = 0, snd_en = 0;
  logic [7:0] wdata = 0, rdata;
  logic [3:0] env = 0;
  logic [2:0] chan;
  logic [11:0] amp;
  logic io_in;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  psg_core i_psg_core (
    .clk_i(clk), .rst_ni(rst_n), .addr_we_i(addr_we), .data_we_i(data_we),
    .wdata_i(wdata), .rdata_o(rdata), .snd_en_i(snd_en), .env_lvl_i(env),
    .chan_o(chan), .amp_o(amp), .io_in_o(io_in)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic wr_sel(input logic [7:0] v);
    @(negedge clk); addr_we = 1; wdata = v;
    @(negedge clk); addr_we = 0;
  endtask

  task automatic wr_dat(input logic [7:0] v);
    @(negedge clk); data_we = 1; wdata = v;
    @(negedge clk); data_we = 0;
  endtask

  task automatic wr_reg(input int idx, input logic [7:0] v);
    wr_sel(8'(idx));
    wr_dat(v);
  endtask

  task automatic one_tick();
    repeat (16) begin @(negedge clk); snd_en = 1; end
    @(negedge clk); snd_en = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [16:0] lfsr;
    do_reset();
    // R10: reset state
    chk("R10 rdata", rdata, 0);
    chk("R10 amp", amp, 0);
    chk("R10 io", io_in, 0);

    // R1: write/read sweep of all registers
    for (int i = 0; i < 16; i++) wr_reg(i, 8'((i * 17) ^ 8'hA5));
    for (int i = 0; i < 16; i++) begin
      wr_sel(8'(i));
      chk("R1 readback", rdata, (i * 17) ^ 8'hA5);
    end
    // R1: upper index bits ignored
    wr_sel(8'h1C);
    chk("R1 upper bits", rdata, (12 * 17) ^ 8'hA5);

    // R2: held index, repeated writes
    wr_sel(8'd9);
    wr_dat(8'h11); wr_dat(8'h22); wr_dat(8'h33);
    chk("R2 last write", rdata, 8'h33);
    wr_sel(8'd8);
    chk("R2 neighbour intact", rdata, (8 * 17) ^ 8'hA5);

    // R9 / R8: levels with mixer fully disabled
    do_reset();
    wr_reg(7, 8'h3F);
    chk("R7 all disabled high", chan, 3'b111);
    chk("R8 dir out", io_in, 0);
    for (int l = 0; l < 16; l++) begin
      wr_reg(8, 8'(l));
      chk("R9 fixed level", amp[3:0], l);
    end
    wr_reg(9, 8'h10);
    wr_reg(10, 8'h1A);
    for (int l = 0; l < 16; l++) begin
      @(negedge clk); env = 4'(l);
      @(negedge clk);
      chk("R9 env level B", amp[7:4], l);
      chk("R9 env overrides C", amp[11:8], l);
    end
    wr_reg(7, 8'h7F);
    chk("R8 dir in", io_in, 1);

    // R3/R4: tones A=0(->1), B=3 (high nibble junk), C=0x101
    do_reset();
    wr_reg(0, 8'h00); wr_reg(1, 8'h00);
    wr_reg(2, 8'h03); wr_reg(3, 8'hF0);
    wr_reg(4, 8'h01); wr_reg(5, 8'hF1);
    wr_reg(7, 8'h38);
    wr_reg(8, 8'h0F); wr_reg(9, 8'h0F); wr_reg(10, 8'h0F);
    chk("R4 tone starts low", chan, 0);
    for (int k = 1; k <= 520; k++) begin
      one_tick();
      chk("R3 tone A period0", chan[0], (k / 1) & 1);
      chk("R4 tone B", chan[1], (k / 3) & 1);
      chk("R3 tone C coarse", chan[2], (k / 257) & 1);
      if (k % 50 == 0) chk("R9 amp A tone", amp[3:0], ((k & 1) != 0) ? 15 : 0);
    end

    // R5/R6/R7: noise period 3 (upper bits junk), A = tone AND noise
    do_reset();
    wr_reg(6, 8'hE3);
    wr_reg(7, 8'h36);
    lfsr = 17'd1;
    for (int k = 1; k <= 90; k++) begin
      one_tick();
      if (k % 3 == 0) lfsr = {lfsr[0] ^ lfsr[3], lfsr[16:1]};
      chk("R7 A tone&noise", chan[0], (k & 1) & int'(lfsr[0]));
      chk("R7 C forced high", chan[2], 1);
    end
    // R5: period 0 acts as 1
    do_reset();
    wr_reg(7, 8'h37);
    lfsr = 17'd1;
    for (int k = 1; k <= 60; k++) begin
      one_tick();
      lfsr = {lfsr[0] ^ lfsr[3], lfsr[16:1]};
      chk("R6 lfsr period0", chan[0], int'(lfsr[0]));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule